// File: doc/BRIEF.md
# Ping-Pong Capture Buffer Manager

This block steers a stream of captured samples into two memory buffers in turn, so that the producer never has to wait while software drains a finished buffer. Software programs a start address for each buffer, one common length counted in samples, the sample format, and which events may interrupt. For each sample the data path stores, the block supplies the next write address. When the active buffer holds the programmed number of samples, the block marks it full, switches to the other buffer and may raise an interrupt.

Software releases a buffer by acknowledging its full flag. If a switch lands on a buffer that software has not yet released, the block flags an overrun and discards incoming samples. Capture then resumes at the start of that buffer once its flag is acknowledged. The memory bus and the sample data path sit outside the block. A stereo left/right pair is reported by one strobe and counts as one sample.

Top module: `capbuf_pingpong`

## Requirements
- R1: After reset, addr_o is 0, buf_sel_o is 0 (buffer A), full_o is 0, overrun_o is 0 and irq_o is 0.
- R2: The low 6 bits of a written start address are discarded. The first address of a buffer is always the written value with bits 5:0 forced to zero.
- R3: Each accepted sample advances addr_o by the byte width of one sample. The mode field uses bit 0 for stereo and bit 1 for 16-bit samples, giving 1 byte (mono 8), 2 bytes (stereo 8 or mono 16) or 4 bytes (stereo 16). Without a sample strobe or a register write, addr_o and buf_sel_o hold.
- R4: When the accepted sample count in the active buffer reaches the programmed size, that buffer's full flag (full_o bit 0 for A, bit 1 for B) is set and buf_sel_o toggles. addr_o then points at the start of the other buffer. A size of 0 behaves like a size of 1.
- R5: Acknowledge bit 0 clears full_o[0] and bit 1 clears full_o[1]. If a buffer completes in the same cycle its flag is acknowledged, the flag ends up set.
- R6: When a switch targets a buffer whose full flag is still set after any same-cycle acknowledge, overrun_o is set. A sample strobe that arrives while the active buffer is full is discarded: addr_o does not move, no count is taken, and overrun_o is set.
- R7: Once the stalled buffer is acknowledged, the next samples are written from its start address.
- R8: irq_o is the OR of (full_o[0] AND enable bit 4), (full_o[1] AND enable bit 5) and (overrun_o AND enable bit 6) of the control register.
- R9: Acknowledge bit 2 clears overrun_o.
- R10: A register write with wr_sel_i 0 loads start address A, 1 loads start address B, 2 loads the size from the low bits, and 3 loads the control word (mode in bits 1:0, interrupt enables in bits 6:4).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 2 | Register select |
| wr_data_i | input | ADDR_W | Register write data |
| ack_i | input | 3 | Acknowledge strobes: bit 0 full A, bit 1 full B, bit 2 overrun |
| sample_done_i | input | 1 | One sample (or stereo pair) has been stored |
| addr_o | output | ADDR_W | Byte address for the next sample |
| buf_sel_o | output | 1 | Active buffer, 0 = A, 1 = B |
| full_o | output | 2 | Full flags, bit 0 = A, bit 1 = B |
| overrun_o | output | 1 | Overrun flag |
| irq_o | output | 1 | Interrupt request |

## Verification
The hardest state to reach is the stall: a switch that lands on a still-full buffer, followed by discarded strobes, and then a resume at the correct base once that buffer is released. The bench reaches it by withholding acknowledges while it feeds more than two buffers' worth of strobes, for every mode and for several sizes including 0. It then releases one buffer and feeds another full buffer plus one extra strobe, so that the stall occurs a second time on the other side. A directed case places an acknowledge in the same cycle as the completion it would cancel.

// File: rtl/capbuf_pkg.sv
package capbuf_pkg;
  localparam int ALIGN_BITS = 6;

  typedef enum logic [1:0] {
    SEL_BASE_A = 2'd0,
    SEL_BASE_B = 2'd1,
    SEL_SIZE   = 2'd2,
    SEL_CTRL   = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic wide;
    logic stereo;
  } mode_t;

  typedef struct packed {
    logic ovr;
    logic full_b;
    logic full_a;
  } irq_en_t;

  function automatic logic [2:0] bytes_per_sample(mode_t m);
    case ({m.wide, m.stereo})
      2'b00:   return 3'd1;
      2'b01,
      2'b10:   return 3'd2;
      default: return 3'd4;
    endcase
  endfunction
endpackage

// File: rtl/capbuf_regs.sv
module capbuf_regs
  import capbuf_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int SIZE_W = 12
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       wr_en_i,
  input  logic [1:0]                 wr_sel_i,
  input  logic [ADDR_W-1:0]          wr_data_i,
  output logic [1:0][ADDR_W-1:0]     base_o,
  output logic [SIZE_W-1:0]          size_o,
  output mode_t                      mode_o,
  output irq_en_t                    ie_o
);
  localparam int HI_W = ADDR_W - ALIGN_BITS;

  logic [1:0][HI_W-1:0] base_hi_q;

  for (genvar b = 0; b < 2; b++) begin : g_base
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                  base_hi_q[b] <= '0;
      else if (wr_en_i && wr_sel_i == 2'(b))        base_hi_q[b] <= wr_data_i[ADDR_W-1:ALIGN_BITS];
    end
    assign base_o[b] = {base_hi_q[b], {ALIGN_BITS{1'b0}}};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      size_o <= '0;
      mode_o <= '0;
      ie_o   <= '0;
    end else if (wr_en_i) begin
      if (reg_sel_e'(wr_sel_i) == SEL_SIZE) size_o <= wr_data_i[SIZE_W-1:0];
      if (reg_sel_e'(wr_sel_i) == SEL_CTRL) begin
        mode_o <= mode_t'(wr_data_i[1:0]);
        ie_o   <= irq_en_t'(wr_data_i[6:4]);
      end
    end
  end
endmodule

// File: rtl/capbuf_seq.sv
module capbuf_seq #(
  parameter int SIZE_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sample_i,
  input  logic [SIZE_W-1:0] size_i,
  input  logic [2:0]        ack_i,
  output logic              active_o,
  output logic [1:0]        full_o,
  output logic              ovr_o,
  output logic              advance_o,
  output logic              restart_o
);
  logic              active_q, active_n;
  logic [SIZE_W-1:0] cnt_q, cnt_n;
  logic [1:0]        full_q, full_n;
  logic              ovr_q, ovr_n;
  logic              accept, last, tgt;

  assign tgt    = ~active_q;
  assign accept = sample_i && !full_q[active_q];
  // size 0 completes on every sample, same as size 1
  assign last   = accept && ({1'b0, cnt_q} + 1'b1 >= {1'b0, size_i});

  always_comb begin
    active_n = active_q;
    cnt_n    = cnt_q;
    full_n   = full_q & ~ack_i[1:0];
    ovr_n    = ovr_q & ~ack_i[2];
    if (sample_i && full_q[active_q]) ovr_n = 1'b1;
    if (last) begin
      full_n[active_q] = 1'b1;
      cnt_n            = '0;
      active_n         = tgt;
      if (full_n[tgt]) ovr_n = 1'b1;
    end else if (accept) begin
      cnt_n = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
      full_q   <= '0;
      ovr_q    <= 1'b0;
    end else begin
      active_q <= active_n;
      cnt_q    <= cnt_n;
      full_q   <= full_n;
      ovr_q    <= ovr_n;
    end
  end

  assign active_o  = active_q;
  assign full_o    = full_q;
  assign ovr_o     = ovr_q;
  assign advance_o = accept && !last;
  assign restart_o = last;
endmodule

// File: rtl/capbuf_addr.sv
module capbuf_addr #(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 14
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   advance_i,
  input  logic                   restart_i,
  input  logic [2:0]             step_i,
  input  logic [1:0][ADDR_W-1:0] base_i,
  input  logic                   active_i,
  output logic [ADDR_W-1:0]      addr_o
);
  logic [OFF_W-1:0] off_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        off_q <= '0;
    else if (restart_i) off_q <= '0;
    else if (advance_i) off_q <= off_q + OFF_W'(step_i);
  end

  assign addr_o = base_i[active_i] + ADDR_W'(off_q);
endmodule

// File: rtl/capbuf_pingpong.sv
module capbuf_pingpong
  import capbuf_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int SIZE_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [1:0]        wr_sel_i,
  input  logic [ADDR_W-1:0] wr_data_i,
  input  logic [2:0]        ack_i,
  input  logic              sample_done_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              buf_sel_o,
  output logic [1:0]        full_o,
  output logic              overrun_o,
  output logic              irq_o
);
  localparam int OFF_W = SIZE_W + 2;

  logic [1:0][ADDR_W-1:0] base;
  logic [SIZE_W-1:0]      size;
  mode_t                  mode;
  irq_en_t                ie;
  logic                   advance, restart;

  capbuf_regs #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W)) i_regs (
    .clk_i, .rst_ni, .wr_en_i, .wr_sel_i, .wr_data_i,
    .base_o(base), .size_o(size), .mode_o(mode), .ie_o(ie)
  );

  capbuf_seq #(.SIZE_W(SIZE_W)) i_seq (
    .clk_i, .rst_ni,
    .sample_i(sample_done_i), .size_i(size), .ack_i,
    .active_o(buf_sel_o), .full_o, .ovr_o(overrun_o),
    .advance_o(advance), .restart_o(restart)
  );

  capbuf_addr #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) i_addr (
    .clk_i, .rst_ni,
    .advance_i(advance), .restart_i(restart),
    .step_i(bytes_per_sample(mode)),
    .base_i(base), .active_i(buf_sel_o), .addr_o
  );

  assign irq_o = |({overrun_o, full_o} & ie);
endmodule

// File: rtl/capbuf_chk.sv
module capbuf_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic [2:0]        ack_i,
  input logic              sample_done_i,
  input logic [ADDR_W-1:0] addr_o,
  input logic              buf_sel_o,
  input logic [1:0]        full_o,
  input logic              overrun_o,
  input logic              irq_o
);
  // R2
  base_aligned_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(buf_sel_o) |-> addr_o[5:0] == 6'd0);

  // R3
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sample_done_i && !wr_en_i) |=> ($stable(addr_o) && $stable(buf_sel_o)));

  // R4
  full_a_switch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(full_o[0]) |-> buf_sel_o);

  // R4
  full_b_switch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(full_o[1]) |-> !buf_sel_o);

  // R6
  discard_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sample_done_i && full_o[buf_sel_o] && !wr_en_i) |=> $stable(addr_o));

  // R6
  discard_ovr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sample_done_i && full_o[buf_sel_o] && !ack_i[2]) |=> overrun_o);

  // R8
  irq_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o == 2'b00 && !overrun_o) |-> !irq_o);

  // R9
  ovr_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i[2] && !sample_done_i) |=> !overrun_o);
endmodule

bind capbuf_pingpong capbuf_chk #(.ADDR_W(ADDR_W)) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .ack_i(ack_i),
  .sample_done_i(sample_done_i), .addr_o(addr_o), .buf_sel_o(buf_sel_o),
  .full_o(full_o), .overrun_o(overrun_o), .irq_o(irq_o)
);

// File: tb/test_capbuf_pingpong.sv
module test_capbuf_pingpong;
  localparam int ADDR_W = 32;
  localparam int SIZE_W = 8;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              wr_en_i = 1'b0;
  logic [1:0]        wr_sel_i = '0;
  logic [ADDR_W-1:0] wr_data_i = '0;
  logic [2:0]        ack_i = '0;
  logic              sample_done_i = 1'b0;
  logic [ADDR_W-1:0] addr_o;
  logic              buf_sel_o;
  logic [1:0]        full_o;
  logic              overrun_o;
  logic              irq_o;

  capbuf_pingpong #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W)) i_capbuf_pingpong (.*);

  always #5 clk_i = ~clk_i;

  int n_cmp = 0, n_bad = 0;
  logic [31:0] eb [2];
  int          esz, ecnt, eoff, ebps;
  logic        esel, eovr;
  logic [1:0]  efull;
  logic [2:0]  eie;

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic compare_all(string tag);
    chk({tag, " R3 addr"}, addr_o, eb[esel] + 32'(eoff));
    chk({tag, " R4 sel"}, 32'(buf_sel_o), 32'(esel));
    chk({tag, " R4 full"}, 32'(full_o), 32'(efull));
    chk({tag, " R6 ovr"}, 32'(overrun_o), 32'(eovr));
    chk({tag, " R8 irq"}, 32'(irq_o), 32'(|({eovr, efull} & eie)));
  endtask

  task automatic do_reset();
    @(negedge clk_i); rst_ni = 1'b0;
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  task automatic wr(input logic [1:0] s, input logic [31:0] d);
    @(negedge clk_i); wr_en_i = 1'b1; wr_sel_i = s; wr_data_i = d;
    @(negedge clk_i); wr_en_i = 1'b0;
  endtask

  task automatic samp();
    @(negedge clk_i); sample_done_i = 1'b1;
    @(negedge clk_i); sample_done_i = 1'b0;
    if (!efull[esel]) begin
      if (ecnt + 1 >= esz) begin
        efull[esel] = 1'b1; ecnt = 0; eoff = 0;
        if (efull[~esel]) eovr = 1'b1;
        esel = ~esel;
      end else begin
        ecnt++; eoff += ebps;
      end
    end else eovr = 1'b1;
  endtask

  task automatic do_ack(input logic [2:0] a);
    @(negedge clk_i); ack_i = a;
    @(negedge clk_i); ack_i = '0;
    efull &= ~a[1:0];
    if (a[2]) eovr = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    do_reset();
    // R1 reset state
    chk("R1 addr", addr_o, 0);
    chk("R1 sel", 32'(buf_sel_o), 0);
    chk("R1 full", 32'(full_o), 0);
    chk("R1 ovr", 32'(overrun_o), 0);
    chk("R1 irq", 32'(irq_o), 0);

    // R5: completion and acknowledge of the same flag in one cycle, set wins
    wr(2'd2, 32'd1);
    @(negedge clk_i); sample_done_i = 1'b1; ack_i = 3'b001;
    @(negedge clk_i); sample_done_i = 1'b0; ack_i = 3'b000;
    chk("R5 set wins full", 32'(full_o), 32'b01);
    chk("R5 set wins sel", 32'(buf_sel_o), 1);
    @(negedge clk_i); ack_i = 3'b001;
    @(negedge clk_i); ack_i = 3'b000;
    chk("R5 ack clears", 32'(full_o), 0);

    // Sweep: every mode, several sizes, with a stall and a resume each time
    for (int m = 0; m < 4; m++) begin
      for (int si = 0; si < 5; si++) begin
        int sz, nsamp;
        sz = (si == 4) ? 5 : si;
        do_reset();
        eb[0] = 32'h0000_1000 + 32'(m * 256);
        eb[1] = 32'h0004_2040;
        eie   = 3'(m + si);
        // R10 register selects, R2 low address bits discarded
        wr(2'd0, eb[0] | 32'h2A);
        wr(2'd1, eb[1] | 32'h13);
        wr(2'd2, 32'(sz));
        wr(2'd3, 32'(m) | (32'(eie) << 4));
        esz = sz; ecnt = 0; eoff = 0; esel = 1'b0; efull = '0; eovr = 1'b0;
        ebps = 1 << ((m & 1) + (m >> 1));
        compare_all("R10 R2 start");
        nsamp = 3 * ((sz == 0) ? 1 : sz) + 2;
        for (int k = 0; k < nsamp; k++) begin
          samp();
          compare_all("R4 R6 fill");
        end
        do_ack(3'b001);
        compare_all("R5 ack A");
        for (int k = 0; k < ((sz == 0) ? 1 : sz) + 1; k++) begin
          samp();
          compare_all("R7 resume");
        end
        do_ack(3'b111);
        compare_all("R9 ack all");
      end
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule